// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns a stream of packed 16-bit stereo samples into a three-wire serial audio signal: a bit clock, a word-select (channel) line and a data line. Samples arrive as 32-bit words through a small input FIFO with a valid/ready handshake. The upper half of each word is the right channel and is sent first; the lower half is the left channel. Every bit is sent MSB first. All output timing is a fixed count of system clock cycles: one bit lasts six cycles, with the bit clock low for three cycles and high for three.

A frame is 32 bit periods, or 192 cycles. At each frame boundary the block takes one word from the FIFO. If the FIFO is empty, it sends the word it already holds again, so an underrun repeats the last stereo sample and never inserts silence. One configuration input selects standard alignment, in which word-select changes one bit before each channel's MSB, or left-justified alignment, in which it changes together with the MSB. A second input swaps which output pin carries the bit clock and which carries word-select.

An enable input starts output at the next frame boundary. If enable is low when a frame ends, the block stops and idles with the bit clock high.

Top module: `stereo_serial_tx`

## Requirements
- R1: After reset, pin_a and pin_b are both 1, sdata is 0, in_ready is 1, and the held stereo word is zero, so a frame sent before any word is written carries all-zero data.
- R2: While running, each bit period is exactly 6 clock cycles, with the bit clock low for 3 cycles and then high for 3 cycles. A frame is 32 consecutive bit periods.
- R3: sdata changes only in the cycle where the bit clock falls, and it stays constant for the whole high phase of the bit clock.
- R4: Bit period k of a frame (k = 0..31) carries bit 31-k of the stereo word. Bits 31:16 are the right channel and are sent first, MSB first.
- R5: In standard alignment (cfg_ljust = 0), word-select is 1 during bit periods 0..14 and 31 and is 0 during 15..30, so it changes one bit before each channel's MSB. Word-select changes only while the bit clock is low.
- R6: In left-justified alignment (cfg_ljust = 1), word-select is 1 during bit periods 0..15 and 0 during 16..31. The alignment is sampled once per frame, at the frame start.
- R7: At each frame start exactly one word is taken from the FIFO if one is present. If the FIFO is empty, the previously sent word is sent again. Two words are never taken less than 192 cycles apart.
- R8: With cfg_swap = 0, pin_a carries the bit clock and pin_b carries word-select. With cfg_swap = 1, the two are exchanged and the timing is unchanged.
- R9: Output starts at the first frame boundary after en is high. If en is low when a frame ends, the block halts with the bit clock at 1 and word-select at the level of the last bit period (1 in standard alignment, 0 in left-justified alignment).
- R10: The input FIFO holds FIFO_DEPTH words and returns them in order. in_ready is 1 exactly when the FIFO is not full, and a word is accepted when in_valid and in_ready are both 1 at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable, sampled at frame boundaries |
| cfg_ljust | input | 1 | 0 = standard alignment, 1 = left-justified alignment |
| cfg_swap | input | 1 | 1 = exchange the bit-clock and word-select pins |
| in_data | input | 32 | Stereo word: right channel in [31:16], left channel in [15:0] |
| in_valid | input | 1 | in_data holds a word to write |
| in_ready | output | 1 | FIFO can accept a word |
| pin_a | output | 1 | Bit clock (cfg_swap = 0) or word-select (cfg_swap = 1), registered |
| pin_b | output | 1 | Word-select (cfg_swap = 0) or bit clock (cfg_swap = 1), registered |
| sdata | output | 1 | Serial data, registered |

## Verification
Assertions check the following on every cycle: the bit counter advances only on the last cycle of a bit period; data is held steady while the bit clock is high; word-select moves only during a bit-clock low phase; the FIFO occupancy stays within its depth; and no two words are taken less than a frame apart. Other behaviour can only be shown by the bench's scenarios. This covers the bit order within a frame, the exact word-select position relative to each MSB in both alignments, the replay of the held word when the FIFO runs dry, the pin exchange and the idle levels after a stop. The bench decodes these from the pins, sweeping all four combinations of alignment and swap with different FIFO fill levels.

// File: rtl/sts_pkg.sv
package sts_pkg;

  // One sample of the three serial lines before pin assignment.
  typedef struct packed {
    logic clk_lvl;
    logic sel_lvl;
    logic dat;
  } pin_set_t;

endpackage

// File: rtl/sts_fifo.sv
module sts_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             rd_take,
  output logic             rd_avail,
  output logic [WIDTH-1:0] rd_data
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             push;

  assign wr_ready = (cnt != CNT_W'(DEPTH));
  assign rd_avail = (cnt != '0);
  assign push     = wr_valid && wr_ready;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
      if (rd_take && rd_avail) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + PTR_W'(1);
      case ({push, rd_take && rd_avail})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/sts_sequencer.sv
module sts_sequencer
  import sts_pkg::*;
#(
  parameter int unsigned SMP_W    = 16,
  parameter int unsigned HALF_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 cfg_ljust,
  input  logic                 word_avail,
  input  logic [2*SMP_W-1:0]   word_in,
  output logic                 word_take,
  output pin_set_t             lines
);
  localparam int unsigned FRAME_BITS = 2 * SMP_W;
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS);
  localparam int unsigned PH_CNT     = 2 * HALF_CYC;
  localparam int unsigned PH_W       = $clog2(PH_CNT);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PH_CNT - 1);

  logic [BIT_W-1:0]      bit_idx;
  logic [PH_W-1:0]       phase;
  logic [FRAME_BITS-1:0] cur;
  logic                  lj_q;
  logic                  at_end;
  logic                  ws_std, ws_lj;

  // Idle is the frozen last cycle of a frame: clock high, no advance.
  assign at_end    = (bit_idx == BIT_LAST) && (phase == PH_LAST);
  assign word_take = at_end && en && word_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= BIT_LAST;
      phase   <= PH_LAST;
      cur     <= '0;
      lj_q    <= 1'b0;
    end else if (at_end) begin
      if (en) begin
        bit_idx <= '0;
        phase   <= '0;
        lj_q    <= cfg_ljust;
        if (word_avail) cur <= word_in;
      end
    end else if (phase == PH_LAST) begin
      phase   <= '0;
      bit_idx <= bit_idx + BIT_W'(1);
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  assign ws_std = (bit_idx < BIT_W'(SMP_W - 1)) || (bit_idx == BIT_LAST);
  assign ws_lj  = (bit_idx < BIT_W'(SMP_W));

  always_comb begin
    lines.clk_lvl = (phase >= PH_W'(HALF_CYC));
    lines.sel_lvl = lj_q ? ws_lj : ws_std;
    lines.dat     = cur[BIT_LAST - bit_idx];
  end

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_LAST) |=> (bit_idx == $past(bit_idx)));
  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LAST && bit_idx != BIT_LAST) |=> (bit_idx == $past(bit_idx) + BIT_W'(1)));

endmodule

// File: rtl/sts_pinmux.sv
module sts_pinmux
  import sts_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     swap,
  input  pin_set_t lines,
  output logic     pin_a,
  output logic     pin_b,
  output logic     pin_d
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_a <= 1'b1;
      pin_b <= 1'b1;
      pin_d <= 1'b0;
    end else begin
      pin_a <= swap ? lines.sel_lvl : lines.clk_lvl;
      pin_b <= swap ? lines.clk_lvl : lines.sel_lvl;
      pin_d <= lines.dat;
    end
  end

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lines.clk_lvl && $past(lines.clk_lvl)) |-> $stable(lines.dat));
  // R5
  sel_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lines.sel_lvl) |-> !lines.clk_lvl);

endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import sts_pkg::*;
#(
  parameter int unsigned SMP_W      = 16,
  parameter int unsigned HALF_CYC   = 3,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               cfg_ljust,
  input  logic               cfg_swap,
  input  logic [2*SMP_W-1:0] in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic               pin_a,
  output logic               pin_b,
  output logic               sdata
);
  localparam int unsigned WORD_W    = 2 * SMP_W;
  localparam int unsigned FRAME_CYC = 2 * HALF_CYC * WORD_W;
  localparam int unsigned GAP_W     = $clog2(FRAME_CYC + 1);

  logic              avail, take;
  logic [WORD_W-1:0] head;
  pin_set_t          lines;

  sts_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_data(in_data), .wr_valid(in_valid), .wr_ready(in_ready),
    .rd_take(take), .rd_avail(avail), .rd_data(head)
  );

  sts_sequencer #(.SMP_W(SMP_W), .HALF_CYC(HALF_CYC)) u_seq (
    .clk(clk), .rst(rst), .en(en), .cfg_ljust(cfg_ljust),
    .word_avail(avail), .word_in(head), .word_take(take), .lines(lines)
  );

  sts_pinmux u_pins (
    .clk(clk), .rst(rst), .swap(cfg_swap), .lines(lines),
    .pin_a(pin_a), .pin_b(pin_b), .pin_d(sdata)
  );

  // Spacing monitor for fetches.
  logic [GAP_W-1:0] gap;
  logic             seen_take;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= '0;
      seen_take <= 1'b0;
    end else if (take) begin
      gap       <= '0;
      seen_take <= 1'b1;
    end else if (gap < GAP_W'(FRAME_CYC)) begin
      gap <= gap + GAP_W'(1);
    end
  end

  // R7
  take_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (take && seen_take) |-> (gap >= GAP_W'(FRAME_CYC - 1)));

endmodule

// File: tb/sim_stereo_serial_tx.sv
`timescale 1ns/1ps
module sim_stereo_serial_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, cfg_ljust = 1'b0, cfg_swap = 1'b0;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready, pin_a, pin_b, sdata;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 1'b0;
  logic [31:0] hold_w = '0;
  logic [31:0] wq [4];

  always #10 clk = ~clk;

  stereo_serial_tx u0 (
    .clk(clk), .rst(rst), .en(en), .cfg_ljust(cfg_ljust), .cfg_swap(cfg_swap),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .pin_a(pin_a), .pin_b(pin_b), .sdata(sdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_cfg(input logic lj, input logic sw, input int nw, input int nfr, input int seed);
    int rises = 0, since_rise = 0, since_fall = 0, guard = 0;
    logic prev = 1'b1, bc, ws, rise_sd = 1'b0, exp_ws;
    logic [31:0] w;
    @(negedge clk);
    cfg_ljust = lj;
    cfg_swap  = sw;
    for (int i = 0; i < nw; i++) begin
      wq[i] = (32'h9E37_79B9 * (seed + i + 1)) ^ (32'h0F0F_3C3C << i);
      push(wq[i]);
    end
    // R10: full FIFO deasserts ready
    if (nw == 4) chk(in_ready == 1'b0, "R10 ready when full", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    while (rises < nfr * 32 && guard < 20000) begin
      @(negedge clk);
      guard++;
      bc = sw ? pin_b : pin_a;
      ws = sw ? pin_a : pin_b;
      since_rise++;
      since_fall++;
      if (prev && !bc) begin
        // R2: high phase length
        if (rises > 0) chk(since_rise == 3, "R2 high phase", since_rise, 3);
        since_fall = 0;
      end
      if (bc && prev && rises > 0)
        chk(sdata == rise_sd, "R3 data stable while clock high", {31'd0, sdata}, {31'd0, rise_sd});
      if (!prev && bc) begin
        int f, k;
        f = rises / 32;
        k = rises % 32;
        chk(since_fall == 3, "R2 low phase", since_fall, 3);
        if (rises > 0) chk(since_rise == 6, "R2 bit period", since_rise, 6);
        w = (f < nw) ? wq[f] : ((nw > 0) ? wq[nw-1] : hold_w);
        // R4 bit order, R7 replay of held word on underrun
        chk(sdata == w[31-k], (f < nw) ? "R4 data bit" : "R7 replayed bit", {31'd0, sdata}, {31'd0, w[31-k]});
        exp_ws = lj ? (k < 16) : ((k < 15) || (k == 31));
        chk(ws == exp_ws, lj ? "R6 word-select" : "R5 word-select", {26'd0, k[4:0], ws}, {26'd0, k[4:0], exp_ws});
        if (rises == 1 && nw == 4)
          chk(in_ready == 1'b1, "R7 one word taken at frame start", {31'd0, in_ready}, 32'd1);
        if (rises == nfr * 32 - 16) en = 1'b0;
        rise_sd = sdata;
        rises++;
        since_rise = 0;
      end
      prev = bc;
    end
    chk(rises == nfr * 32, "R2 bit periods sent", rises, nfr * 32);
    repeat (12) @(negedge clk);
    // R9 idle after stop, R8 pin placement
    begin
      logic exp_a, exp_b;
      exp_a = sw ? ~lj : 1'b1;
      exp_b = sw ? 1'b1 : ~lj;
      chk(pin_a == exp_a && pin_b == exp_b, "R9/R8 idle pins", {30'd0, pin_a, pin_b}, {30'd0, exp_a, exp_b});
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        chk((sw ? pin_b : pin_a) == 1'b1, "R9 clock held high when stopped", {31'd0, sw ? pin_b : pin_a}, 32'd1);
      end
    end
    if (nw > 0) hold_w = wq[nw-1];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pin_a == 1'b1 && pin_b == 1'b1, "R1 idle clock/select", {30'd0, pin_a, pin_b}, 32'd3);
    chk(sdata == 1'b0, "R1 idle data", {31'd0, sdata}, 32'd0);
    chk(in_ready == 1'b1, "R1 ready after reset", {31'd0, in_ready}, 32'd1);
    run_cfg(1'b0, 1'b0, 0, 1, 0);   // empty FIFO: zero word
    run_cfg(1'b0, 1'b0, 4, 6, 10);  // full FIFO then underrun
    run_cfg(1'b1, 1'b1, 2, 3, 20);
    run_cfg(1'b0, 1'b1, 1, 2, 30);
    run_cfg(1'b1, 1'b0, 3, 4, 40);
    run_cfg(1'b0, 1'b0, 0, 1, 50);  // replay after mode change
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule